// File: doc/BRIEF.md
# Decoder Status Register with Host Attention

This block keeps the status word that a paging decoder hands to its host controller. The word holds the synchronisation state, a frame-information-valid bit, the current frame and cycle numbers, the low-battery level, and a set of sticky event flags. The host clears the sticky flags by reading them. The core sends the block one-cycle event strobes: sync found, sync lost, search-period expiry, end of block 0, a frame-information word with its frame and cycle values, end of frame, minute tick, battery-pin sample and transmit-buffer overflow.

The block also owns the decoder's ON bit. The host writes that bit. A transmit-buffer overflow forces it low and also pulses a flush request to the transmit buffer. An attention request is raised while an enabled event is pending. The host is told to take the status word when it polls and no other data is waiting.

Top module: `dsr_top`

## Requirements
- R1: After reset the status word is all zero, and `attnReq`, `decOn` and `flushTx` are 0.
- R2: A write with `onWr` loads `onWrData` into `decOn` on the next edge. `txOverflow` forces `decOn` to 0 and sets the overflow flag (bit 18). It also raises `flushTx` for exactly one cycle, starting at the edge after the strobe.
- R3: While ON, `syncFound` sets the sync flag (bit 12) and `syncLost` clears it. Turning off clears the flag, and `syncFound` while off is ignored.
- R4: After each turn-on, the first `syncFound` or `searchExpired` sets the sync-update flag (bit 13). After that first update, `searchExpired` has no effect.
- R5: After that first update, every change of the sync flag sets the sync-update flag. A sync flag cleared by turning off does not set it.
- R6: The frame-info-valid flag (bit 11) goes to 1 at `endBlock0` once a frame-information word has arrived while synchronised. `syncLost` or turn-off clears it.
- R7: The frame number (bits 6:0) and cycle number (bits 10:7) load at `endBlock0` from the most recent frame-information word. A word arriving in the same cycle as `endBlock0` is used directly.
- R8: The low-battery flag (bit 14) follows each `batSample` of `batPin`. At turn-on it loads the inverse of `cfgBatPol`. The low-battery-update flag (bit 15) sets when a sample differs from the current low-battery flag. The turn-on load never sets it.
- R9: `minuteTick` sets the minute flag (bit 16). `endFrame` sets the end-of-frame flag (bit 17) only when `afmCount` is nonzero, any `taeActive` bit is set, or `cfgForceAll` is 1.
- R10: `hostRead` clears bits 13, 15, 16, 17 and 18. A flag set in the same cycle as the read stays set.
- R11: `attnReq` = (bit13 & `cfgSmuEn`) | (bit16 & `cfgMtEn`) | bit17 | bit15 | bit18.
- R12: `statusSel` = `hostPoll` & !`otherPending`. Bits 23:19 of the status word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| onWr | input | 1 | Host write strobe for the ON bit |
| onWrData | input | 1 | Value to write into ON |
| syncFound | input | 1 | Sync words received |
| syncLost | input | 1 | Synchronisation lost |
| searchExpired | input | 1 | Sync search period expired |
| endBlock0 | input | 1 | End of block 0 of a frame |
| fiWordValid | input | 1 | Valid frame-information word |
| fiFrame | input | FRAME_W | Frame number carried by that word |
| fiCycle | input | CYCLE_W | Cycle number carried by that word |
| endFrame | input | 1 | End of frame |
| minuteTick | input | 1 | One minute elapsed |
| batSample | input | 1 | Battery pin sampled this cycle |
| batPin | input | 1 | Sampled battery pin level |
| txOverflow | input | 1 | Transmit buffer overflowed |
| hostRead | input | 1 | Host read of the status word (clears sticky flags) |
| hostPoll | input | 1 | Host poll |
| otherPending | input | 1 | Other data waiting for the host |
| cfgSmuEn | input | 1 | Attention enable for sync-update |
| cfgMtEn | input | 1 | Attention enable for minute flag |
| cfgBatPol | input | 1 | Battery pin polarity |
| cfgForceAll | input | 1 | Force all-frame mode |
| afmCount | input | AFM_W | All-frame enable counter |
| taeActive | input | TAE_N | One bit per nonzero temporary-address counter |
| statusWord | output | WORD_W | Packed status word |
| statusSel | output | 1 | Status word is the reply to this poll |
| attnReq | output | 1 | Host attention request |
| decOn | output | 1 | Decoder ON bit |
| flushTx | output | 1 | Transmit buffer flush pulse |

## Verification
The risky overlap is a host read that lands in the same cycle as a new event on a clear-on-read flag. The bench provokes it by issuing `hostRead` together with a battery sample that differs from the stored level. It expects the update flag to survive that edge and to clear only on a later, separate read. A second overlap is a frame-information word that arrives in the very cycle of `endBlock0`. For that case the bench checks that the new frame number, not the held one, appears in the word.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  localparam int FLAG_N = 8;

  typedef struct packed {
    logic boe;
    logic eof;
    logic mt;
    logic lbu;
    logic lb;
    logic smu;
    logic sm;
    logic fiv;
  } flags_t;

  typedef struct packed {
    logic turnOff;
    logic smSet;
    logic smClr;
    logic smuSet;
    logic fiCapture;
    logic fivSet;
    logic fivClr;
    logic frameLoad;
    logic lbInit;
    logic lbLoad;
    logic lbuSet;
    logic mtSet;
    logic eofSet;
    logic boeSet;
    logic rdClr;
  } strobe_t;

endpackage

// File: rtl/dsr_ctrl.sv
module dsr_ctrl
  import dsr_pkg::*;
#(
  parameter int AFM_W = 4,
  parameter int TAE_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             onWr,
  input  logic             onWrData,
  input  logic             syncFound,
  input  logic             syncLost,
  input  logic             searchExpired,
  input  logic             endBlock0,
  input  logic             fiWordValid,
  input  logic             endFrame,
  input  logic             minuteTick,
  input  logic             batSample,
  input  logic             batPin,
  input  logic             txOverflow,
  input  logic             hostRead,
  input  logic [AFM_W-1:0] afmCount,
  input  logic [TAE_N-1:0] taeActive,
  input  logic             cfgForceAll,
  input  logic             smNow,
  input  logic             lbNow,
  output strobe_t          stb,
  output logic             decOn,
  output logic             flushTx
);

  logic onReg, firstDone, holdValid, flushReg;
  logic turnOn, active, afmActive, fiNow;

  always_comb begin
    turnOn      = onWr & onWrData & ~onReg & ~txOverflow;
    stb.turnOff = onReg & ((onWr & ~onWrData) | txOverflow);
    active      = onReg & ~stb.turnOff;
    afmActive   = (|afmCount) | (|taeActive) | cfgForceAll;

    stb.smSet   = active & syncFound & ~syncLost & ~smNow;
    stb.smClr   = active & syncLost & smNow;
    stb.smuSet  = active & (firstDone ? (stb.smSet | stb.smClr)
                                      : (syncFound | searchExpired));

    fiNow         = active & fiWordValid & smNow & ~syncLost;
    stb.fiCapture = fiNow;
    stb.fivClr    = stb.turnOff | (active & syncLost);
    stb.fivSet    = active & endBlock0 & (holdValid | fiNow) & ~syncLost;
    stb.frameLoad = active & endBlock0 & (holdValid | fiNow);

    stb.lbInit  = turnOn;
    stb.lbLoad  = batSample & ~turnOn;
    stb.lbuSet  = batSample & ~turnOn & (batPin != lbNow);

    stb.mtSet   = minuteTick;
    stb.eofSet  = endFrame & afmActive;
    stb.boeSet  = txOverflow;
    stb.rdClr   = hostRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onReg     <= 1'b0;
      firstDone <= 1'b0;
      holdValid <= 1'b0;
      flushReg  <= 1'b0;
    end else begin
      flushReg <= txOverflow;
      if (txOverflow)  onReg <= 1'b0;
      else if (onWr)   onReg <= onWrData;
      if (turnOn)            firstDone <= 1'b0;
      else if (stb.smuSet)   firstDone <= 1'b1;
      if (stb.fivClr)        holdValid <= 1'b0;
      else if (fiNow)        holdValid <= 1'b1;
    end
  end

  assign decOn   = onReg;
  assign flushTx = flushReg;

endmodule

// File: rtl/dsr_data.sv
module dsr_data
  import dsr_pkg::*;
#(
  parameter int FRAME_W = 7,
  parameter int CYCLE_W = 4,
  parameter int WORD_W  = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [FRAME_W-1:0] fiFrame,
  input  logic [CYCLE_W-1:0] fiCycle,
  input  logic               batPin,
  input  logic               cfgBatPol,
  input  logic               cfgSmuEn,
  input  logic               cfgMtEn,
  output flags_t             flags,
  output logic [WORD_W-1:0]  statusWord,
  output logic               attnReq
);

  localparam int USED_W = FRAME_W + CYCLE_W + FLAG_N;
  localparam int PAD_W  = WORD_W - USED_W;

  flags_t             flagsQ;
  logic [FRAME_W-1:0] frameQ, holdFrame;
  logic [CYCLE_W-1:0] cycleQ, holdCycle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ    <= '0;
      frameQ    <= '0;
      cycleQ    <= '0;
      holdFrame <= '0;
      holdCycle <= '0;
    end else begin
      if (stb.fivClr)      flagsQ.fiv <= 1'b0;
      else if (stb.fivSet) flagsQ.fiv <= 1'b1;

      if (stb.turnOff | stb.smClr) flagsQ.sm <= 1'b0;
      else if (stb.smSet)          flagsQ.sm <= 1'b1;

      flagsQ.smu <= stb.smuSet | (flagsQ.smu & ~stb.rdClr);
      flagsQ.lbu <= stb.lbuSet | (flagsQ.lbu & ~stb.rdClr);
      flagsQ.mt  <= stb.mtSet  | (flagsQ.mt  & ~stb.rdClr);
      flagsQ.eof <= stb.eofSet | (flagsQ.eof & ~stb.rdClr);
      flagsQ.boe <= stb.boeSet | (flagsQ.boe & ~stb.rdClr);

      if (stb.lbInit)      flagsQ.lb <= ~cfgBatPol;
      else if (stb.lbLoad) flagsQ.lb <= batPin;

      if (stb.fiCapture) begin
        holdFrame <= fiFrame;
        holdCycle <= fiCycle;
      end
      if (stb.frameLoad) begin
        frameQ <= stb.fiCapture ? fiFrame : holdFrame;
        cycleQ <= stb.fiCapture ? fiCycle : holdCycle;
      end
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign statusWord = {{PAD_W{1'b0}}, flagsQ, cycleQ, frameQ};
    end else begin : g_nopad
      assign statusWord = {flagsQ, cycleQ, frameQ};
    end
  endgenerate

  assign attnReq = (flagsQ.smu & cfgSmuEn) | (flagsQ.mt & cfgMtEn) |
                   flagsQ.eof | flagsQ.lbu | flagsQ.boe;
  assign flags = flagsQ;

endmodule

// File: rtl/dsr_top.sv
module dsr_top
  import dsr_pkg::*;
#(
  parameter int FRAME_W = 7,
  parameter int CYCLE_W = 4,
  parameter int WORD_W  = 24,
  parameter int AFM_W   = 4,
  parameter int TAE_N   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               onWr,
  input  logic               onWrData,
  input  logic               syncFound,
  input  logic               syncLost,
  input  logic               searchExpired,
  input  logic               endBlock0,
  input  logic               fiWordValid,
  input  logic [FRAME_W-1:0] fiFrame,
  input  logic [CYCLE_W-1:0] fiCycle,
  input  logic               endFrame,
  input  logic               minuteTick,
  input  logic               batSample,
  input  logic               batPin,
  input  logic               txOverflow,
  input  logic               hostRead,
  input  logic               hostPoll,
  input  logic               otherPending,
  input  logic               cfgSmuEn,
  input  logic               cfgMtEn,
  input  logic               cfgBatPol,
  input  logic               cfgForceAll,
  input  logic [AFM_W-1:0]   afmCount,
  input  logic [TAE_N-1:0]   taeActive,
  output logic [WORD_W-1:0]  statusWord,
  output logic               statusSel,
  output logic               attnReq,
  output logic               decOn,
  output logic               flushTx
);

  strobe_t stb;
  flags_t  flags;

  dsr_ctrl #(.AFM_W(AFM_W), .TAE_N(TAE_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .onWr(onWr), .onWrData(onWrData),
    .syncFound(syncFound), .syncLost(syncLost), .searchExpired(searchExpired),
    .endBlock0(endBlock0), .fiWordValid(fiWordValid), .endFrame(endFrame),
    .minuteTick(minuteTick), .batSample(batSample), .batPin(batPin),
    .txOverflow(txOverflow), .hostRead(hostRead), .afmCount(afmCount),
    .taeActive(taeActive), .cfgForceAll(cfgForceAll),
    .smNow(flags.sm), .lbNow(flags.lb),
    .stb(stb), .decOn(decOn), .flushTx(flushTx)
  );

  dsr_data #(.FRAME_W(FRAME_W), .CYCLE_W(CYCLE_W), .WORD_W(WORD_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .fiFrame(fiFrame), .fiCycle(fiCycle),
    .batPin(batPin), .cfgBatPol(cfgBatPol), .cfgSmuEn(cfgSmuEn),
    .cfgMtEn(cfgMtEn), .flags(flags), .statusWord(statusWord),
    .attnReq(attnReq)
  );

  assign statusSel = hostPoll & ~otherPending;

endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
  parameter int FRAME_W = 7,
  parameter int CYCLE_W = 4,
  parameter int WORD_W  = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              onWr,
  input logic              onWrData,
  input logic              txOverflow,
  input logic              minuteTick,
  input logic              hostRead,
  input logic              cfgBatPol,
  input logic [WORD_W-1:0] statusWord,
  input logic              attnReq,
  input logic              decOn,
  input logic              flushTx
);

  localparam int B = FRAME_W + CYCLE_W;

  // R2: overflow turns the decoder off, flushes and records the loss
  p_flush_on_ovf_r2: assert property (@(posedge clk) disable iff (!rstN)
    txOverflow |=> (flushTx && !decOn && statusWord[B+7]));

  // R3 / R6: while off, neither sync nor frame-info-valid is held
  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !decOn |-> (!statusWord[B+1] && !statusWord[B]));

  // R6: frame-info-valid only while synchronised
  p_fiv_needs_sync_r6: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[B] |-> statusWord[B+1]);

  // R8: turn-on loads the inverse polarity into the battery level
  p_lb_turn_on_r8: assert property (@(posedge clk) disable iff (!rstN)
    (onWr && onWrData && !decOn && !txOverflow) |=>
      (statusWord[B+3] == !$past(cfgBatPol)));

  // R9: minute tick is recorded
  p_minute_sets_r9: assert property (@(posedge clk) disable iff (!rstN)
    minuteTick |=> statusWord[B+5]);

  // R10: a read with no new tick clears the minute flag
  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hostRead && !minuteTick) |=> !statusWord[B+5]);

  // R11: an overflow flag always demands attention
  p_boe_attn_r11: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[B+7] |-> attnReq);

endmodule

bind dsr_top dsr_checker #(.FRAME_W(FRAME_W), .CYCLE_W(CYCLE_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .onWr(onWr), .onWrData(onWrData),
  .txOverflow(txOverflow), .minuteTick(minuteTick), .hostRead(hostRead),
  .cfgBatPol(cfgBatPol), .statusWord(statusWord), .attnReq(attnReq),
  .decOn(decOn), .flushTx(flushTx)
);

// File: tb/sim_dsr_top.sv
`timescale 1ns/1ps
module sim_dsr_top;

  localparam int B_FIV = 11, B_SM = 12, B_SMU = 13, B_LB = 14;
  localparam int B_LBU = 15, B_MT = 16, B_EOF = 17, B_BOE = 18;

  // {afmCount[3:0], taeActive[1:0], cfgForceAll, expectedEof}
  localparam logic [7:0] EOF_TAB [6] = '{
    8'b0000_00_0_0, 8'b0001_00_0_1, 8'b0000_01_0_1,
    8'b0000_10_0_1, 8'b0000_00_1_1, 8'b1000_00_0_1
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic onWr = 0, onWrData = 0, syncFound = 0, syncLost = 0, searchExpired = 0;
  logic endBlock0 = 0, fiWordValid = 0, endFrame = 0, minuteTick = 0;
  logic [6:0] fiFrame = '0;
  logic [3:0] fiCycle = '0;
  logic batSample = 0, batPin = 0, txOverflow = 0, hostRead = 0;
  logic hostPoll = 0, otherPending = 0, cfgSmuEn = 0, cfgMtEn = 0;
  logic cfgBatPol = 0, cfgForceAll = 0;
  logic [3:0] afmCount = '0;
  logic [1:0] taeActive = '0;
  logic [23:0] statusWord;
  logic statusSel, attnReq, decOn, flushTx;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dsr_top u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic readClr();
    hostRead = 1; tick(); hostRead = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 word", statusWord, 0);
    chk("R1 attn/on/flush", {attnReq, decOn, flushTx}, 0);
    rstN = 1; tick();

    // R12 poll selection
    hostPoll = 1; #1; chk("R12 sel", statusSel, 1);
    otherPending = 1; #1; chk("R12 sel pending", statusSel, 0);
    hostPoll = 0; otherPending = 0;

    // R2 / R8 turn on with polarity 0
    onWr = 1; onWrData = 1; tick(); onWr = 0;
    chk("R2 on", decOn, 1);
    chk("R8 lb init", statusWord[B_LB], 1);
    chk("R8 no lbu at on", statusWord[B_LBU], 0);

    // R4 first update by search expiry
    searchExpired = 1; tick(); searchExpired = 0;
    chk("R4 smu first", {statusWord[B_SMU], statusWord[B_SM]}, 2'b10);
    chk("R11 smu masked", attnReq, 0);
    cfgSmuEn = 1; #1; chk("R11 smu enabled", attnReq, 1);
    readClr(); chk("R10 smu read", statusWord[B_SMU], 0);
    searchExpired = 1; tick(); searchExpired = 0;
    chk("R4 later expiry ignored", statusWord[B_SMU], 0);

    // R3 / R5 sync found
    syncFound = 1; tick(); syncFound = 0;
    chk("R3 sm set", statusWord[B_SM], 1);
    chk("R5 smu on change", statusWord[B_SMU], 1);
    readClr();

    // R6 / R7 frame info
    fiWordValid = 1; fiFrame = 7'h25; fiCycle = 4'h9; tick(); fiWordValid = 0;
    chk("R6 fiv waits block0", statusWord[B_FIV], 0);
    chk("R7 frame not yet", statusWord[10:0], 0);
    endBlock0 = 1; tick(); endBlock0 = 0;
    chk("R6 fiv set", statusWord[B_FIV], 1);
    chk("R7 frame/cycle", statusWord[10:0], {4'h9, 7'h25});
    fiWordValid = 1; endBlock0 = 1; fiFrame = 7'h26; fiCycle = 4'hA; tick();
    fiWordValid = 0; endBlock0 = 0;
    chk("R7 same-cycle bypass", statusWord[10:0], {4'hA, 7'h26});

    // R3 / R5 / R6 sync lost
    syncLost = 1; tick(); syncLost = 0;
    chk("R3 sm cleared", statusWord[B_SM], 0);
    chk("R5 smu on loss", statusWord[B_SMU], 1);
    chk("R6 fiv cleared", statusWord[B_FIV], 0);
    readClr();
    syncFound = 1; tick(); syncFound = 0;
    readClr();

    // R8 battery
    batSample = 1; batPin = 1; tick(); batSample = 0;
    chk("R8 same sample", {statusWord[B_LBU], statusWord[B_LB]}, 2'b01);
    batSample = 1; batPin = 0; tick(); batSample = 0;
    chk("R8 change", {statusWord[B_LBU], statusWord[B_LB]}, 2'b10);
    chk("R11 lbu attn", attnReq, 1);
    // R10 read collides with a new update
    readClr();
    chk("R10 read clears lbu", statusWord[B_LBU], 0);
    batSample = 1; batPin = 1; hostRead = 1; tick(); batSample = 0; hostRead = 0;
    chk("R10 set wins over read", {statusWord[B_LBU], statusWord[B_LB]}, 2'b11);
    readClr();
    chk("R10 later read clears", statusWord[B_LBU], 0);

    // R9 / R11 minute
    minuteTick = 1; tick(); minuteTick = 0;
    chk("R9 mt set", statusWord[B_MT], 1);
    chk("R11 mt masked", attnReq, 0);
    cfgMtEn = 1; #1; chk("R11 mt enabled", attnReq, 1);
    readClr(); chk("R10 mt read", statusWord[B_MT], 0);

    // R9 end of frame qualification table
    for (int i = 0; i < 6; i++) begin
      afmCount = EOF_TAB[i][7:4]; taeActive = EOF_TAB[i][3:2];
      cfgForceAll = EOF_TAB[i][1];
      endFrame = 1; tick(); endFrame = 0;
      chk($sformatf("R9 eof row %0d", i), statusWord[B_EOF], EOF_TAB[i][0]);
      chk($sformatf("R11 eof attn row %0d", i), attnReq, EOF_TAB[i][0]);
      readClr();
      chk($sformatf("R10 eof read row %0d", i), statusWord[B_EOF], 0);
    end
    afmCount = '0; taeActive = '0; cfgForceAll = 0;

    // R2 / R3 / R5 overflow forces off
    txOverflow = 1; tick(); txOverflow = 0;
    chk("R2 off by overflow", decOn, 0);
    chk("R2 flush pulse", flushTx, 1);
    chk("R2 boe", statusWord[B_BOE], 1);
    chk("R3 off clears sm", statusWord[B_SM], 0);
    chk("R5 off no smu", statusWord[B_SMU], 0);
    chk("R11 boe attn", attnReq, 1);
    tick();
    chk("R2 flush one cycle", flushTx, 0);
    readClr(); chk("R10 boe read", statusWord[B_BOE], 0);
    syncFound = 1; tick(); syncFound = 0;
    chk("R3 sync ignored while off", statusWord[B_SM], 0);

    // R8 / R4 turn on again with polarity 1
    cfgBatPol = 1; onWr = 1; onWrData = 1; tick(); onWr = 0;
    chk("R8 lb inverse pol", statusWord[B_LB], 0);
    chk("R8 on load no lbu", statusWord[B_LBU], 0);
    syncFound = 1; tick(); syncFound = 0;
    chk("R4 first update by sync", {statusWord[B_SMU], statusWord[B_SM]}, 2'b11);
    readClr();
    onWr = 1; onWrData = 0; tick(); onWr = 0;
    chk("R2 host off", decOn, 0);
    chk("R5 host off no smu", {statusWord[B_SMU], statusWord[B_SM]}, 2'b00);
    chk("R12 unused bits", statusWord[23:19], 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule